// File: doc/BRIEF.md
# Shadow Memory Region Router

This block decides, for every memory access in the upper 256 KB of the first megabyte, whether the cycle is served by on-board DRAM or passed to the external expansion bus. Reads and writes are decided separately. This allows firmware to copy a ROM image into DRAM with reads going to the ROM and writes going to DRAM. It can then switch reads over to the fast copy and leave writes disabled, which protects the copy.

Four byte-wide configuration registers hold the policy. The register at offset 0x44 carries one read bit and one write bit for the whole 64 KB firmware page at 0xF0000. The registers at 0x45, 0x46 and 0x47 each govern one 64 KB option-ROM page, at 0xE0000, 0xD0000 and 0xC0000 respectively. Each of these registers splits its page into four 16 KB segments, with a read nibble and a write nibble. The routing outputs are combinational from the access address and the stored bits. A register write is visible to accesses from the clock edge that stores it. The bus cycle and the DRAM controller sit outside this block.

Top module: `shadow_route_dec`

## Requirements
- R1: For an address in 0xF0000–0xFFFFF, `rd_internal` equals bit 1 of the register at offset 0x44.
- R2: For an address in 0xF0000–0xFFFFF, `wr_internal` equals bit 0 of the register at offset 0x44.
- R3: A write to offset 0x44 stores the written byte ANDed with 0xCB. Writes to 0x45, 0x46 and 0x47 store all eight bits. `cfg_rdata` returns the stored value of the register selected by `cfg_addr`.
- R4: Offset 0x45 controls the page at 0xE0000, offset 0x46 controls 0xD0000, and offset 0x47 controls 0xC0000. A register never affects any other page.
- R5: Within a controlled page, segment i (i = 0..3) spans base + i·0x4000 for 16 KB. In that segment, `rd_internal` equals bit 4+i of the page's register and `wr_internal` equals bit i.
- R6: After reset, every register reads 0 and every address routes reads and writes externally (both outputs 0).
- R7: Any address below 0xC0000 or at or above 0x100000 gives `rd_internal` = 0 and `wr_internal` = 0, whatever the registers hold.
- R8: A write with `cfg_we` high is stored at the next rising clock edge, and routing changes only from that edge onward. Writes to any other offset change no register and no routing, and such an offset reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset for write and read-back |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Stored value at `cfg_addr` |
| mem_addr | input | 24 | Physical address of the current access |
| rd_internal | output | 1 | 1 = a read at `mem_addr` goes to DRAM, 0 = external bus |
| wr_internal | output | 1 | 1 = a write at `mem_addr` goes to DRAM, 0 = external bus |

## Verification
The bench probes both the first and the last byte of every 16 KB segment in every page. A decoder that took the segment index from the wrong address bits, or that swapped the read and write nibbles, would route the wrong half of a page. It also writes distinct patterns to each page register, which catches a reversed page order where 0x45 steers 0xC0000. It probes just below 0xC0000 and just above 0xFFFFF, which exposes a decoder that drops the upper address bits and aliases 1 MB upward. Finally, it samples routing before and after the storing edge, and writes to neighbouring offsets 0x43 and 0x48, to show that routing does not change early and that stray offsets leave every register unchanged.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int unsigned CFG_W     = 8;
  localparam int unsigned N_WIN     = 3;
  localparam int unsigned SEG_N     = 4;
  localparam int unsigned PAGE_LSB  = 16;
  localparam int unsigned MB_LSB    = 20;
  localparam logic [7:0]  SYS_OFS   = 8'h44;
  localparam logic [7:0]  SYS_MASK  = 8'hCB;
  localparam logic [3:0]  TOP_PAGE  = 4'hF;

  typedef struct packed {
    logic rd;
    logic wr;
  } route_t;
endpackage

// File: rtl/shadow_rst_sync.sv
module shadow_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_pkg::*;
#(
  parameter int unsigned NW = N_WIN
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CFG_W-1:0]       cfg_addr,
  input  logic [CFG_W-1:0]       cfg_wdata,
  output logic [CFG_W-1:0]       cfg_rdata,
  output logic [CFG_W-1:0]       sys_q,
  output logic [NW-1:0][CFG_W-1:0] win_q
);
  logic [CFG_W-1:0]         sys_d;
  logic [NW-1:0][CFG_W-1:0] win_d;
  logic                     sys_sel;
  logic [NW-1:0]            win_sel;

  assign sys_sel = cfg_we && (cfg_addr == SYS_OFS);

  always_comb begin
    sys_d = sys_q;
    if (sys_sel) sys_d = cfg_wdata & SYS_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sys_q <= '0;
    else if (sys_sel) sys_q <= sys_d;
  end

  for (genvar k = 0; k < NW; k++) begin : g_win
    localparam logic [CFG_W-1:0] OFS = SYS_OFS + CFG_W'(k) + 8'd1;

    assign win_sel[k] = cfg_we && (cfg_addr == OFS);

    always_comb begin
      win_d[k] = win_q[k];
      if (win_sel[k]) win_d[k] = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          win_q[k] <= '0;
      else if (win_sel[k]) win_q[k] <= win_d[k];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == SYS_OFS) cfg_rdata = sys_q;
    for (int k = 0; k < NW; k++) begin
      if (cfg_addr == SYS_OFS + CFG_W'(k) + 8'd1) cfg_rdata = win_q[k];
    end
  end

  // R3: masked-off bits of the firmware register never become set
  a_r3_sys_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_q & ~SYS_MASK) == '0);

  // R8: a write to the firmware register lands on the next edge
  a_r8_sys_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == SYS_OFS) |=> (sys_q == ($past(cfg_wdata) & SYS_MASK)));

  // R8: without a strobe, no register moves
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(sys_q) && $stable(win_q)));
endmodule

// File: rtl/shadow_win_dec.sv
module shadow_win_dec
  import shadow_pkg::*;
#(
  parameter int unsigned NW = N_WIN,
  parameter int unsigned AW = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            mem_addr,
  input  logic [CFG_W-1:0]         sys_q,
  input  logic [NW-1:0][CFG_W-1:0] win_q,
  output route_t                   route
);
  localparam int unsigned SEG_LSB = PAGE_LSB - $clog2(SEG_N);

  logic                       below_mb;
  logic [3:0]                 page;
  logic [$clog2(SEG_N)-1:0]   seg;
  logic                       top_hit;
  logic [NW-1:0]              win_hit;
  logic [NW-1:0]              win_rd;
  logic [NW-1:0]              win_wr;
  logic                       unused_addr;
  logic                       unused_sys;

  if (AW > MB_LSB) begin : g_hi
    assign below_mb = (mem_addr[AW-1:MB_LSB] == '0);
  end else begin : g_nohi
    assign below_mb = 1'b1;
  end

  assign page        = mem_addr[MB_LSB-1:PAGE_LSB];
  assign seg         = mem_addr[PAGE_LSB-1:SEG_LSB];
  assign top_hit     = below_mb && (page == TOP_PAGE);
  assign unused_addr = ^mem_addr[SEG_LSB-1:0];
  assign unused_sys  = ^sys_q[CFG_W-1:2];

  for (genvar k = 0; k < NW; k++) begin : g_win
    localparam logic [3:0] PG = TOP_PAGE - 4'(k) - 4'd1;
    assign win_hit[k] = below_mb && (page == PG);
    assign win_rd[k]  = win_hit[k] && win_q[k][{1'b1, seg}];
    assign win_wr[k]  = win_hit[k] && win_q[k][{1'b0, seg}];
  end

  always_comb begin
    route = '0;
    if (top_hit) begin
      route.rd = sys_q[1];
      route.wr = sys_q[0];
    end else begin
      route.rd = |win_rd;
      route.wr = |win_wr;
    end
  end

  // R7: outside the controlled span nothing routes internally
  a_r7_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (!below_mb || page < (TOP_PAGE - 4'(NW))) |-> (route == '0));

  // R1: firmware page reads follow the read bit
  a_r1_top_rd: assert property (@(posedge clk) disable iff (!rst_n)
    top_hit |-> (route.rd == sys_q[1]));

  // R2: firmware page writes follow the write bit
  a_r2_top_wr: assert property (@(posedge clk) disable iff (!rst_n)
    top_hit |-> (route.wr == sys_q[0]));

  // R4: at most one page region is ever selected
  a_r4_one_page: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_hit, top_hit}));
endmodule

// File: rtl/shadow_route_dec.sv
module shadow_route_dec
  import shadow_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic [AW-1:0]    mem_addr,
  output logic             rd_internal,
  output logic             wr_internal
);
  logic                        rst_n_sync;
  logic [CFG_W-1:0]            sys_q;
  logic [N_WIN-1:0][CFG_W-1:0] win_q;
  route_t                      route;

  shadow_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  shadow_cfg_regs #(.NW(N_WIN)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .sys_q     (sys_q),
    .win_q     (win_q)
  );

  shadow_win_dec #(.NW(N_WIN), .AW(AW)) i_dec (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .mem_addr (mem_addr),
    .sys_q    (sys_q),
    .win_q    (win_q),
    .route    (route)
  );

  assign rd_internal = route.rd;
  assign wr_internal = route.wr;

  // R6: while reset is held, every access routes externally
  a_r6_reset_ext: assert property (@(posedge clk)
    !rst_n_sync |-> (!rd_internal && !wr_internal));
endmodule

// File: tb/test_shadow_route_dec.sv
module test_shadow_route_dec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [23:0] mem_addr;
  logic        rd_internal;
  logic        wr_internal;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_sys;
  logic [7:0] m_win [3];

  always #10 clk = ~clk;

  shadow_route_dec i_shadow_route_dec (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .rd_internal(rd_internal), .wr_internal(wr_internal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_route(input logic [23:0] a);
    logic [3:0] pg;
    int seg;
    if (a[23:20] != 0) return 2'b00;
    pg  = a[19:16];
    seg = int'(a[15:14]);
    if (pg == 4'hF) return {m_sys[1], m_sys[0]};
    if (pg >= 4'hC) begin
      int k = 14 - int'(pg);
      return {m_win[k][4+seg], m_win[k][seg]};
    end
    return 2'b00;
  endfunction

  // drive at negedge, check one step later
  task automatic probe(input string tag, input logic [23:0] a);
    mem_addr = a;
    #1;
    chk(tag, {30'd0, rd_internal, wr_internal}, {30'd0, exp_route(a)});
  endtask

  task automatic cfg_wr(input logic [7:0] ofs, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (ofs == 8'h44) m_sys = val & 8'hCB;
    else if (ofs >= 8'h45 && ofs <= 8'h47) m_win[ofs - 8'h45] = val;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] ofs, input logic [7:0] exp);
    cfg_addr = ofs;
    #1;
    chk(tag, {24'd0, cfg_rdata}, {24'd0, exp});
  endtask

  task automatic t_reset;
    for (int o = 8'h44; o <= 8'h47; o++) rd_chk("R6 readback", 8'(o), 8'h00);
    probe("R6 top", 24'h0F8000);
    probe("R6 C page", 24'h0C0000);
    probe("R6 E page", 24'h0EC000);
  endtask

  task automatic t_top_bits;
    for (int v = 0; v < 4; v++) begin
      cfg_wr(8'h44, 8'(v));
      probe("R1 R2 top low", 24'h0F0000);
      probe("R1 R2 top high", 24'h0FFFFF);
    end
  endtask

  task automatic t_masks;
    cfg_wr(8'h44, 8'hFF);
    rd_chk("R3 mask 44", 8'h44, 8'hCB);
    cfg_wr(8'h44, 8'h34);
    rd_chk("R3 mask 44 cleared", 8'h44, 8'h00);
    probe("R3 masked bits no effect", 24'h0F1234);
    cfg_wr(8'h45, 8'hA5); rd_chk("R3 full 45", 8'h45, 8'hA5);
    cfg_wr(8'h46, 8'h3C); rd_chk("R3 full 46", 8'h46, 8'h3C);
    cfg_wr(8'h47, 8'hFF); rd_chk("R3 full 47", 8'h47, 8'hFF);
  endtask

  task automatic t_page_map;
    cfg_wr(8'h45, 8'hFF); cfg_wr(8'h46, 8'h00); cfg_wr(8'h47, 8'h00);
    probe("R4 E on", 24'h0E4000); probe("R4 D off", 24'h0D4000); probe("R4 C off", 24'h0C4000);
    cfg_wr(8'h45, 8'h00); cfg_wr(8'h47, 8'hF0);
    probe("R4 E off", 24'h0E4000); probe("R4 C rd only", 24'h0C4000);
    probe("R4 D still off", 24'h0D8000);
    cfg_wr(8'h46, 8'h0F);
    probe("R4 D wr only", 24'h0DC000);
  endtask

  task automatic t_segments;
    logic [7:0] pat [3] = '{8'h5A, 8'h96, 8'h3C};
    for (int k = 0; k < 3; k++) cfg_wr(8'(8'h45 + k), pat[k]);
    for (int k = 0; k < 3; k++)
      for (int s = 0; s < 4; s++) begin
        logic [23:0] base = 24'h0E0000 - 24'(k) * 24'h10000 + 24'(s) * 24'h4000;
        probe("R5 seg first", base);
        probe("R5 seg last", base + 24'h3FFF);
      end
  endtask

  task automatic t_outside;
    cfg_wr(8'h44, 8'h03);
    for (int k = 0; k < 3; k++) cfg_wr(8'(8'h45 + k), 8'hFF);
    probe("R7 below", 24'h0BFFFF);
    probe("R7 zero", 24'h000000);
    probe("R7 above", 24'h100000);
    probe("R7 alias", 24'h1C0000);
    probe("R7 top alias", 24'hFFFFFF);
    probe("R7 inside ok", 24'h0C0000);
  endtask

  task automatic t_timing;
    cfg_wr(8'h46, 8'h00);
    @(negedge clk);
    mem_addr = 24'h0D0000;
    cfg_we = 1'b1; cfg_addr = 8'h46; cfg_wdata = 8'h11;
    #5;
    chk("R8 before edge", {30'd0, rd_internal, wr_internal}, 32'd0);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_win[1] = 8'h11;
    chk("R8 after edge", {30'd0, rd_internal, wr_internal}, 32'd3);
    @(negedge clk);
    cfg_wr(8'h43, 8'hFF);
    cfg_wr(8'h48, 8'h00);
    rd_chk("R8 stray 43 reads 0", 8'h43, 8'h00);
    rd_chk("R8 stray 48 reads 0", 8'h48, 8'h00);
    rd_chk("R8 46 kept", 8'h46, 8'h11);
    probe("R8 routing kept", 24'h0D0000);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog all-reqs act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; mem_addr = '0;
    m_sys = '0; m_win = '{default: 8'h00};
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_top_bits();
    t_masks();
    t_page_map();
    t_segments();
    t_outside();
    t_timing();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule